// File: doc/BRIEF.md
# Register Bank Address Decoder

This block sits between a simple word-addressed bus and a bank of register flip-flops. It has no clock and no state. A write address comes in and is turned into one-hot write strobes, one strobe for each register word, together with a write-OK flag. A separate read address comes in and is turned into read-select pulses, one for each word, a read data word and a read-OK flag. The two paths are fully independent, so a read and a write can be decoded in the same cycle.

The register map is fixed at elaboration by parameters. Each register has a bit width, a first word index and a write-only flag.

- A register wider than a bus word takes several consecutive word addresses. Its most-significant slice sits at the lowest of those addresses.
- A slice narrower than the bus word is zero-extended on readback.
- A write-only register accepts writes, but reads back as zero with a failed status.
- The block as a whole answers only to addresses inside its own aligned area.
- Unmapped words and out-of-area addresses give a not-OK status and no strobes.

Top module: `regbank_addr_decoder`

## Requirements
- R1: The word index is address bits [5:2] (area of 64 bytes, 4 bytes per word). Address bits [1:0] have no effect on any output.
- R2: A write address that hits a mapped word drives exactly that word's `wr_sel` bit to 1 and all other bits to 0, and sets `wr_ok` to 1. Bit numbering is as follows: bits 0 and 1 belong to the 64-bit register (bit 0 = low word, bit 1 = high word), bit 2 to the 16-bit register and bit 3 to the write-only register.
- R3: An address inside the area that hits no mapped word gives `wr_sel` = 0 and `wr_ok` = 0 on the write side. On the read side it gives `rd_sel` = 0, `rd_ok` = 0 and `rd_data` = 0.
- R4: An address whose bits [11:6] differ from the area base (0x400) gives the same all-zero, not-OK result as R3, on whichever path it is applied to.
- R5: The 64-bit register sits at word indices 0 and 1 in most-significant-first order. Word 0 reads back bits 63:32 and word 1 reads back bits 31:0.
- R6: The 16-bit register at word index 3 reads back zero-extended to 32 bits, with `rd_ok` = 1.
- R7: The 32-bit write-only register at word index 5 behaves differently on each path. A write to it is accepted (`wr_sel[3]` = 1, `wr_ok` = 1). A read of it returns `rd_data` = 0, `rd_ok` = 0 and `rd_sel` = 0.
- R8: A read of a mapped, readable word drives exactly that word's `rd_sel` bit to 1, using the bit numbering of R2.
- R9: The read outputs depend only on `rd_addr` and the register contents. The write outputs depend only on `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_addr | input | 12 | Byte address of the write access |
| rd_addr | input | 12 | Byte address of the read access |
| reg_rd_val | input | 112 | Register contents, packed {wo32, rw16, rw64} from the LSB up |
| wr_sel | output | 4 | One-hot write strobe for each register word |
| wr_ok | output | 1 | Write address decoded to a mapped word |
| rd_sel | output | 4 | One-hot read-select pulse for each readable word |
| rd_data | output | 32 | Read data word |
| rd_ok | output | 1 | Read address decoded to a readable word |

## Verification
The assertions assume two things about their inputs: the parameter map places no two register words on the same index, and the address inputs are free of X. Under those conditions the strobe vectors can never hold more than one bit. The bench keeps within this by applying only the default, non-overlapping map. It always drives both addresses with known values, sweeping every word and byte offset inside the area and a handful of addresses outside it. The write address is always paired with a different read address, so that any coupling between the two paths becomes visible.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rbd_word_decode.sv
module rbd_word_decode #(
  parameter int ADDR_W     = 12,
  parameter int BYTE_BITS  = 2,
  parameter int AREA_LOG2  = 6,
  parameter int AREA_BASE  = 'h400,
  parameter int WORD_W     = 32,
  parameter int NREG       = 3,
  parameter int REG_WIDTH [NREG] = '{64, 16, 32},
  parameter int REG_WORD  [NREG] = '{0, 3, 5},
  parameter int TOT_WORDS  = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 in_area,
  output logic [TOT_WORDS-1:0] hit
);
  import rbd_pkg::*;

  localparam int IDX_W = AREA_LOG2 - BYTE_BITS;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(AREA_BASE);

  function automatic int word_off(input int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += ceil_div(REG_WIDTH[j], WORD_W);
    return s;
  endfunction

  logic [IDX_W-1:0] idx;
  logic             unused_byte_bits;

  assign in_area          = (addr[ADDR_W-1:AREA_LOG2] == BASE_V[ADDR_W-1:AREA_LOG2]);
  assign idx              = addr[AREA_LOG2-1:BYTE_BITS];
  assign unused_byte_bits = ^addr[BYTE_BITS-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam int NW = ceil_div(REG_WIDTH[k], WORD_W);
    for (genvar i = 0; i < NW; i++) begin : g_word
      localparam int GIDX = word_off(k) + i;
      // slice i (0 = least significant) sits at the highest address of the span minus i
      localparam int WADDR = REG_WORD[k] + NW - 1 - i;
      assign hit[GIDX] = in_area && (idx == IDX_W'(WADDR));
    end
  end

  always_comb begin
    if (!in_area) begin
      AST_OUT_OF_AREA_QUIET: assert (hit == '0); // R4
    end
    AST_HIT_ONEHOT0: assert ($onehot0(hit)); // R2
  end
endmodule

// File: rtl/rbd_rd_mux.sv
module rbd_rd_mux #(
  parameter int WORD_W    = 32,
  parameter int NREG      = 3,
  parameter int REG_WIDTH [NREG] = '{64, 16, 32},
  parameter bit REG_WO    [NREG] = '{1'b0, 1'b0, 1'b1},
  parameter int TOT_WORDS = 4,
  parameter int TOT_BITS  = 112
) (
  input  logic [TOT_WORDS-1:0] hit,
  input  logic [TOT_BITS-1:0]  vals,
  output logic [TOT_WORDS-1:0] rd_sel,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_ok
);
  import rbd_pkg::*;

  function automatic int word_off(input int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += ceil_div(REG_WIDTH[j], WORD_W);
    return s;
  endfunction

  function automatic int bit_off(input int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += REG_WIDTH[j];
    return s;
  endfunction

  logic [WORD_W-1:0]    word_val [TOT_WORDS];
  logic [TOT_WORDS-1:0] readable;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam int NW = ceil_div(REG_WIDTH[k], WORD_W);
    for (genvar i = 0; i < NW; i++) begin : g_word
      localparam int GIDX = word_off(k) + i;
      localparam int LSB  = bit_off(k) + i * WORD_W;
      localparam int SW   = min_int(WORD_W, REG_WIDTH[k] - i * WORD_W);
      assign word_val[GIDX] = WORD_W'(vals[LSB +: SW]);
      assign readable[GIDX] = !REG_WO[k];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < TOT_WORDS; g++) begin
      if (hit[g] && readable[g]) rd_data = rd_data | word_val[g];
    end
  end

  assign rd_sel = hit & readable;
  assign rd_ok  = |rd_sel;

  always_comb begin
    if (!rd_ok) begin
      AST_NOT_OK_ZERO_DATA: assert (rd_data == '0); // R3
    end else begin
      AST_RD_SEL_SINGLE: assert ($onehot(rd_sel)); // R8
    end
  end
endmodule

// File: rtl/regbank_addr_decoder.sv
module regbank_addr_decoder #(
  parameter int ADDR_W    = 12,
  parameter int BYTE_BITS = 2,
  parameter int AREA_LOG2 = 6,
  parameter int AREA_BASE = 'h400,
  parameter int WORD_W    = 32,
  parameter int NREG      = 3,
  parameter int REG_WIDTH [NREG] = '{64, 16, 32},
  parameter int REG_WORD  [NREG] = '{0, 3, 5},
  parameter bit REG_WO    [NREG] = '{1'b0, 1'b0, 1'b1},
  localparam int TOT_WORDS = rbd_tot_words(),
  localparam int TOT_BITS  = rbd_tot_bits()
) (
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [TOT_BITS-1:0]  reg_rd_val,
  output logic [TOT_WORDS-1:0] wr_sel,
  output logic                 wr_ok,
  output logic [TOT_WORDS-1:0] rd_sel,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_ok
);
  function automatic int rbd_tot_words();
    int s = 0;
    for (int j = 0; j < NREG; j++) s += (REG_WIDTH[j] + WORD_W - 1) / WORD_W;
    return s;
  endfunction

  function automatic int rbd_tot_bits();
    int s = 0;
    for (int j = 0; j < NREG; j++) s += REG_WIDTH[j];
    return s;
  endfunction

  logic [TOT_WORDS-1:0] wr_hit, rd_hit;
  logic                 wr_in_area, rd_in_area;

  rbd_word_decode #(
    .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .AREA_LOG2(AREA_LOG2),
    .AREA_BASE(AREA_BASE), .WORD_W(WORD_W), .NREG(NREG),
    .REG_WIDTH(REG_WIDTH), .REG_WORD(REG_WORD), .TOT_WORDS(TOT_WORDS)
  ) wr_dec_i (
    .addr(wr_addr), .in_area(wr_in_area), .hit(wr_hit)
  );

  rbd_word_decode #(
    .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .AREA_LOG2(AREA_LOG2),
    .AREA_BASE(AREA_BASE), .WORD_W(WORD_W), .NREG(NREG),
    .REG_WIDTH(REG_WIDTH), .REG_WORD(REG_WORD), .TOT_WORDS(TOT_WORDS)
  ) rd_dec_i (
    .addr(rd_addr), .in_area(rd_in_area), .hit(rd_hit)
  );

  rbd_rd_mux #(
    .WORD_W(WORD_W), .NREG(NREG), .REG_WIDTH(REG_WIDTH), .REG_WO(REG_WO),
    .TOT_WORDS(TOT_WORDS), .TOT_BITS(TOT_BITS)
  ) rd_mux_i (
    .hit(rd_hit), .vals(reg_rd_val),
    .rd_sel(rd_sel), .rd_data(rd_data), .rd_ok(rd_ok)
  );

  // write side: every mapped word accepts writes, write-only ones included
  assign wr_sel = wr_hit;
  assign wr_ok  = |wr_hit;

  always_comb begin
    if (wr_ok) begin
      AST_WR_SINGLE_STROBE: assert ($onehot(wr_sel)); // R2
    end
    if (!rd_in_area) begin
      AST_RD_OUTSIDE_NOT_OK: assert (!rd_ok && rd_data == '0); // R4
    end
    if (!wr_in_area) begin
      AST_WR_OUTSIDE_NOT_OK: assert (!wr_ok); // R4
    end
  end
endmodule

// File: tb/regbank_addr_decoder_tb_top.sv
module regbank_addr_decoder_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0]  wr_addr, rd_addr;
  logic [111:0] reg_rd_val;
  logic [3:0]   wr_sel, rd_sel;
  logic         wr_ok, rd_ok;
  logic [31:0]  rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  regbank_addr_decoder dut_i (
    .wr_addr(wr_addr), .rd_addr(rd_addr), .reg_rd_val(reg_rd_val),
    .wr_sel(wr_sel), .wr_ok(wr_ok), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_ok(rd_ok)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (wr=%0h rd=%0h)",
               tag, what, act, exp, wr_addr, rd_addr);
    end
  endtask

  // expected write strobe for a byte address; -1 bits none
  function automatic int exp_widx(input logic [11:0] a);
    if (a[11:6] != 6'h10) return -1;
    case (a[5:2])
      4'd0: return 1;
      4'd1: return 0;
      4'd3: return 2;
      4'd5: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a, input bit rd);
    string t;
    if (a[11:6] != 6'h10) t = "R4";
    else case (a[5:2])
      4'd0, 4'd1: t = "R5";
      4'd3:       t = rd ? "R6" : "R2";
      4'd5:       t = rd ? "R7" : "R7 R2";
      default:    t = "R3";
    endcase
    if (a[1:0] != 2'd0) t = {t, " R1"};
    return {t, " R9"};
  endfunction

  task automatic apply(input logic [11:0] wa, input logic [11:0] ra);
    int wi, ri;
    logic [3:0]  e_wsel, e_rsel;
    logic [31:0] e_data;
    logic [63:0] r64;
    logic [15:0] r16;
    @(posedge clk);
    wr_addr = wa;
    rd_addr = ra;
    @(negedge clk);
    r64 = reg_rd_val[63:0];
    r16 = reg_rd_val[79:64];
    wi = exp_widx(wa);
    ri = exp_widx(ra);
    e_wsel = (wi < 0) ? 4'd0 : 4'(1 << wi);
    e_rsel = (ri < 0 || ri == 3) ? 4'd0 : 4'(1 << ri);
    case (ri)
      1:       e_data = r64[63:32];
      0:       e_data = r64[31:0];
      2:       e_data = {16'd0, r16};
      default: e_data = 32'd0;
    endcase
    check(tag_of(wa, 1'b0), "wr_sel", 64'(wr_sel), 64'(e_wsel));
    check(tag_of(wa, 1'b0), "wr_ok",  64'(wr_ok),  64'(wi >= 0));
    check({tag_of(ra, 1'b1), " R8"}, "rd_sel", 64'(rd_sel), 64'(e_rsel));
    check(tag_of(ra, 1'b1), "rd_ok",  64'(rd_ok),  64'(e_rsel != 0));
    check(tag_of(ra, 1'b1), "rd_data", 64'(rd_data), 64'(e_data));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] outside [5] = '{12'h000, 12'h3FC, 12'h440, 12'h800, 12'hC05};
    wr_addr    = 12'h000;
    rd_addr    = 12'h800;
    reg_rd_val = {32'hCAFEF00D, 16'hBEEF, 64'h1122_3344_5566_7788};
    // idle state with both addresses outside the area (R4)
    @(negedge clk);
    check("R4 idle", "wr_ok", 64'(wr_ok), 64'd0);
    check("R4 idle", "rd_ok", 64'(rd_ok), 64'd0);

    for (int pat = 0; pat < 2; pat++) begin
      if (pat == 1) reg_rd_val = {32'h1234ABCD, 16'h8001, 64'hF0E1_D2C3_B4A5_9687};
      for (int w = 0; w < 16; w++) begin
        for (int b = 0; b < 4; b++) begin
          apply(12'h400 | 12'((15 - w) << 2) | 12'(3 - b),
                12'h400 | 12'(w << 2) | 12'(b));
        end
      end
      for (int o = 0; o < 5; o++) begin
        apply(outside[o], 12'h400 | 12'(o << 2));
        apply(12'h400 | 12'(o << 2), outside[o]);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule